// File: doc/BRIEF.md
# Program and Erase Engine for a Byte-Wide Nonvolatile Array

This block carries out program and erase operations on a small on-chip byte array that models nonvolatile cells. A command decoder upstream sends a one-cycle `start` pulse along with an operation type, a target address and a data byte. The engine then runs the whole algorithm by itself. It sets `busy` while it works and returns to plain array reads when it finishes. The host supplies no timing during an operation.

Programming can only clear bits. Each program pulse stores the bitwise AND of the stored byte and the new data. After each pulse the engine verifies the byte. If the verify fails, it applies another pulse, up to a fixed number of tries. If the last try still fails, it raises a sticky failure flag.

Erase works on one of several equal-size sectors, selected by the top address bits. It first programs every byte of the sector to 0x00. It then verifies each byte for zero, waits out the erase time, and finally sets the whole sector to 0xFF. The erase is the only path that turns a 0 back into a 1.

The controller has six states:
- IDLE: array read mode.
- PULSE: program pulse timing.
- CHECK: program verify.
- ZERO: sector preprogram.
- ZCHECK: sector zero verify.
- ERASE: erase wait.

Its transitions are:
- IDLE→PULSE on start with program.
- IDLE→ZERO on start with erase.
- PULSE→CHECK when the pulse timer expires.
- CHECK→IDLE on a match or on the last failed try.
- CHECK→PULSE on a failed try with tries left.
- ZERO→ZCHECK after the last sector byte.
- ZCHECK→IDLE on a nonzero byte (failure).
- ZCHECK→ERASE after the last byte verifies.
- ERASE→IDLE when the erase timer expires, with the sector filled.

Top module: `pe_engine`

## Requirements
- R1: After reset `busy` and `fail` are 0 and every byte of the array reads 0xFF on `rd_data`.
- R2: A program operation (`op`=0) leaves the addressed byte equal to its old value AND `wdata`, so no bit is ever raised from 0 to 1 by programming.
- R3: A program whose verify passes keeps `busy` high for exactly PROG_CYC+1 cycles and leaves `fail` unchanged.
- R4: A program whose `wdata` has a 1 where the stored byte has a 0 retries MAX_TRIES pulses, keeps `busy` high for MAX_TRIES*(PROG_CYC+1) cycles, and sets `fail` in the cycle `busy` falls.
- R5: `fail` stays set through later operations until `clr_fail` is sampled high while the engine is idle, which clears it on the next cycle.
- R6: An erase (`op`=1) acts on the sector given by the top log2(SECTORS) bits of `addr`. It keeps `busy` high for 2*SEC_BYTES+ERASE_CYC cycles, and afterwards every byte of that sector reads 0xFF while bytes outside it are unchanged.
- R7: During an erase, once the preprogram and verify phases are done (from busy cycle 2*SEC_BYTES+1 onward), every byte of the target sector reads 0x00 until the sector is filled.
- R8: A `start` pulse while `busy` is high is ignored: the running operation's length is unchanged and the array is left as that operation alone would leave it. While idle with no start, the array content does not change.
- R9: After an erase, a program that failed before on the same byte succeeds and leaves `fail` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; array returns to 0xFF |
| start | input | 1 | One-cycle request to begin an operation, taken only when idle |
| op | input | 1 | Operation type: 0 program, 1 sector erase |
| addr | input | ADDR_W | Target byte address; top bits select the sector for erase |
| wdata | input | 8 | Data to program |
| clr_fail | input | 1 | Reset command that clears the failure flag |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array content at `rd_addr`, combinational |
| busy | output | 1 | High while an operation runs |
| fail | output | 1 | Sticky failure flag |

## Verification
The assertions rely on three assumptions about the inputs. First, `clr_fail` is only meaningful while the engine is idle. Second, the failure flag is raised only in the cycle where `busy` drops. Third, a stable read address while the engine is idle should see a stable array.

The stimulus respects these assumptions. It pulses `clr_fail` only after `busy` has fallen, and it changes `rd_addr` only between clock edges. It issues `start` during a busy period only in the one test that checks that such a request is ignored. Every other request waits for the previous operation to finish, so each expected item in the scoreboard matches exactly one busy period.

// File: rtl/pe_pkg.sv
package pe_pkg;

    localparam int BYTE_W = 8;

    localparam logic OP_PROGRAM = 1'b0;
    localparam logic OP_ERASE   = 1'b1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_CHECK,
        ST_ZERO,
        ST_ZCHECK,
        ST_ERASE
    } eng_state_t;

endpackage

// File: rtl/pe_cell_array.sv
module pe_cell_array
    import pe_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int SECTORS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pgm_en,
    input  logic [ADDR_W-1:0]        pgm_addr,
    input  logic [BYTE_W-1:0]        pgm_mask,
    input  logic                     fill_en,
    input  logic [$clog2(SECTORS)-1:0] fill_sec,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [BYTE_W-1:0]        rd_data,
    input  logic [ADDR_W-1:0]        vf_addr,
    output logic [BYTE_W-1:0]        vf_data
);

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SEC_BYTES = DEPTH / SECTORS;

    logic [BYTE_W-1:0] cells [DEPTH];

    // Cells only ever clear bits on a program write; the sector fill is the
    // single path back to all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (fill_en && ((i / SEC_BYTES) == int'(fill_sec)))
                    cells[i] <= '1;
                else if (pgm_en && (i == int'(pgm_addr)))
                    cells[i] <= cells[i] & pgm_mask;
            end
        end
    end

    assign rd_data = cells[rd_addr];
    assign vf_data = cells[vf_addr];

endmodule

// File: rtl/pe_tick_timer.sv
module pe_tick_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    // High in the final cycle of a loaded interval.
    assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/pe_engine.sv
module pe_engine
    import pe_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SECTORS   = 4,
    parameter int PROG_CYC  = 3,
    parameter int ERASE_CYC = 5,
    parameter int MAX_TRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_fail,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              fail
);

    localparam int SEC_W    = $clog2(SECTORS);
    localparam int OFF_W    = ADDR_W - SEC_W;
    localparam int TMAX     = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int TMR_W    = $clog2(TMAX + 1);
    localparam int TRY_W    = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);
    localparam logic [TMR_W-1:0] PROG_T   = TMR_W'(PROG_CYC);
    localparam logic [TMR_W-1:0] ERASE_T  = TMR_W'(ERASE_CYC);

    eng_state_t state_q, state_d;

    logic [ADDR_W-1:0] tgt_addr_q;
    logic [BYTE_W-1:0] tgt_data_q;
    logic [TRY_W-1:0]  tries_q;
    logic [OFF_W-1:0]  idx_q;
    logic              fail_q;

    logic [ADDR_W-1:0] sec_addr;
    logic              idx_last;
    logic              vf_match;
    logic              vf_zero;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_last;

    logic              arr_pgm_en;
    logic [ADDR_W-1:0] arr_pgm_addr;
    logic [BYTE_W-1:0] arr_pgm_mask;
    logic              arr_fill_en;
    logic [ADDR_W-1:0] vf_addr;
    logic [BYTE_W-1:0] vf_data;

    logic              fail_set;
    logic              idx_step;
    logic              try_step;

    assign sec_addr = {tgt_addr_q[ADDR_W-1 -: SEC_W], idx_q};
    assign idx_last = &idx_q;
    assign vf_match = (vf_data == tgt_data_q);
    assign vf_zero  = (vf_data == '0);

    pe_cell_array #(
        .ADDR_W  (ADDR_W),
        .SECTORS (SECTORS)
    ) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (arr_pgm_en),
        .pgm_addr (arr_pgm_addr),
        .pgm_mask (arr_pgm_mask),
        .fill_en  (arr_fill_en),
        .fill_sec (tgt_addr_q[ADDR_W-1 -: SEC_W]),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .vf_addr  (vf_addr),
        .vf_data  (vf_data)
    );

    pe_tick_timer #(
        .CW (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (op == OP_ERASE) ? ST_ZERO : ST_PULSE;
            ST_PULSE:  if (tmr_last) state_d = ST_CHECK;
            ST_CHECK: begin
                if (vf_match || (tries_q == LAST_TRY)) state_d = ST_IDLE;
                else                                   state_d = ST_PULSE;
            end
            ST_ZERO:   if (idx_last) state_d = ST_ZCHECK;
            ST_ZCHECK: begin
                if (!vf_zero)     state_d = ST_IDLE;
                else if (idx_last) state_d = ST_ERASE;
            end
            ST_ERASE:  if (tmr_last) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Control outputs per state
    always_comb begin
        tmr_load     = 1'b0;
        tmr_val      = PROG_T;
        arr_pgm_en   = 1'b0;
        arr_pgm_addr = tgt_addr_q;
        arr_pgm_mask = tgt_data_q;
        arr_fill_en  = 1'b0;
        vf_addr      = tgt_addr_q;
        fail_set     = 1'b0;
        idx_step     = 1'b0;
        try_step     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_load = start && (op == OP_PROGRAM);
            end
            ST_PULSE: begin
                arr_pgm_en = tmr_last;
            end
            ST_CHECK: begin
                if (!vf_match) begin
                    try_step = 1'b1;
                    if (tries_q == LAST_TRY) fail_set = 1'b1;
                    else                     tmr_load = 1'b1;
                end
            end
            ST_ZERO: begin
                arr_pgm_en   = 1'b1;
                arr_pgm_addr = sec_addr;
                arr_pgm_mask = '0;
                idx_step     = 1'b1;
            end
            ST_ZCHECK: begin
                vf_addr  = sec_addr;
                idx_step = 1'b1;
                if (!vf_zero) fail_set = 1'b1;
                else if (idx_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = ERASE_T;
                end
            end
            ST_ERASE: begin
                arr_fill_en = tmr_last;
            end
            default: ;
        endcase
    end

    // Operation context, counters and the sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
            tries_q    <= '0;
            idx_q      <= '0;
            fail_q     <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && start) begin
                tgt_addr_q <= addr;
                tgt_data_q <= wdata;
                tries_q    <= '0;
                idx_q      <= '0;
            end else begin
                if (idx_step) idx_q   <= idx_q + OFF_W'(1);
                if (try_step) tries_q <= tries_q + TRY_W'(1);
            end
            if (fail_set)      fail_q <= 1'b1;
            else if (clr_fail) fail_q <= 1'b0;
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign fail = fail_q;

endmodule

// File: rtl/pe_engine_chk.sv
module pe_engine_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_fail,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic              fail
);

    // R4
    fail_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $fell(busy));

    // R5
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !clr_fail |=> fail);

    // R5
    fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fail && !busy |=> !fail);

    // R8
    idle_array_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && $past(!busy) && $stable(rd_addr) |-> $stable(rd_data));

endmodule

bind pe_engine pe_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_pe_engine.sv
`timescale 1ns/1ps
module tb_pe_engine;

    localparam int AW  = 6;
    localparam int SEC = 4;
    localparam int PC  = 3;
    localparam int EC  = 5;
    localparam int MT  = 4;
    localparam int DEP = 1 << AW;
    localparam int SB  = DEP / SEC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          clr_fail = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;
    logic          fail;

    pe_engine #(.ADDR_W(AW), .SECTORS(SEC), .PROG_CYC(PC), .ERASE_CYC(EC), .MAX_TRIES(MT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .clr_fail(clr_fail), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .fail(fail)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    cycles;
        bit    fl;
        string tag;
    } exp_t;

    exp_t       q[$];
    int         total = 0;
    int         bad = 0;
    int         done_cnt = 0;
    logic [7:0] model [DEP];
    bit         fail_m = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic read_check(input int a, input string tag);
        rd_addr = AW'(a);
        #1;
        check(rd_data == model[a], tag, int'(rd_data), int'(model[a]));
    endtask

    // Scoreboard monitor: measures each busy period and compares with the queue.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (busy) cnt++;
            else if (cnt != 0) begin
                if (q.size() == 0) begin
                    check(1'b0, "unexpected op", cnt, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cnt == e.cycles, {e.tag, " busy cycles"}, cnt, e.cycles);
                    check(fail == e.fl, {e.tag, " fail flag"}, int'(fail), int'(e.fl));
                end
                cnt = 0;
                done_cnt++;
            end
        end
    end

    // Driver: builds the expected item from the requirements and pushes it.
    task automatic push_expect(input bit o, input int a, input logic [7:0] d, input string tag);
        exp_t e;
        e.tag = tag;
        if (o == 1'b0) begin
            logic [7:0] nw;
            bit f;
            nw = model[a] & d;
            f = (nw != d);
            e.cycles = f ? MT * (PC + 1) : PC + 1;
            model[a] = nw;
            fail_m = fail_m | f;
        end else begin
            int s;
            s = a / SB;
            e.cycles = 2 * SB + EC;
            for (int i = 0; i < SB; i++) model[s * SB + i] = 8'hFF;
        end
        e.fl = fail_m;
        q.push_back(e);
    endtask

    task automatic pulse_start(input bit o, input int a, input logic [7:0] d);
        @(negedge clk);
        start = 1'b1; op = o; addr = AW'(a); wdata = d;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(negedge clk);
    endtask

    task automatic run_op(input bit o, input int a, input logic [7:0] d, input string tag);
        int tgt;
        tgt = done_cnt + 1;
        push_expect(o, a, d, tag);
        pulse_start(o, a, d);
        wait_done(tgt);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int tgt;
        bit all_ff;
        for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(fail == 1'b0, "R1 fail", int'(fail), 0);
        all_ff = 1'b1;
        for (int i = 0; i < DEP; i++) begin
            rd_addr = AW'(i);
            #1;
            if (rd_data != 8'hFF) all_ff = 1'b0;
        end
        check(all_ff, "R1 array erased", int'(all_ff), 1);

        // R2 R3: clean program
        run_op(1'b0, 5, 8'hA5, "R3 program pass");
        read_check(5, "R2 program A5");

        // R4: raise attempt fails after all tries, byte keeps AND result
        run_op(1'b0, 5, 8'h3C, "R4 program fail");
        read_check(5, "R2 R4 no bit raised");

        // R5: flag sticky through a later good program
        run_op(1'b0, 5, 8'h04, "R5 sticky");
        read_check(5, "R2 program 04");
        @(negedge clk);
        clr_fail = 1'b1;
        @(negedge clk);
        clr_fail = 1'b0;
        check(fail == 1'b0, "R5 clear", int'(fail), 0);
        fail_m = 1'b0;

        run_op(1'b0, 63, 8'h00, "R3 program zero");
        read_check(63, "R2 program 00");
        run_op(1'b0, 20, 8'h0F, "R3 program sector1");
        read_check(20, "R2 program 0F");

        // R8: start during busy is ignored
        tgt = done_cnt + 1;
        push_expect(1'b0, 36, 8'hF0, "R8 ignore");
        pulse_start(1'b0, 36, 8'hF0);
        start = 1'b1; op = 1'b1; addr = AW'(20);
        @(negedge clk);
        start = 1'b0;
        wait_done(tgt);
        read_check(20, "R8 sector1 untouched");
        read_check(36, "R8 program kept");
        repeat (2) @(negedge clk);
        check(q.size() == 0 && done_cnt == tgt, "R8 no extra op", done_cnt, tgt);

        // R7 R6: erase sector 0 with mid-erase sweep
        tgt = done_cnt + 1;
        push_expect(1'b1, 3, 8'h00, "R6 erase s0");
        pulse_start(1'b1, 3, 8'h00);
        repeat (2 * SB) @(negedge clk);
        begin
            bit all_zero;
            all_zero = 1'b1;
            for (int i = 0; i < SB; i++) begin
                rd_addr = AW'(i);
                #0.5;
                if (rd_data != 8'h00) all_zero = 1'b0;
            end
            check(all_zero && busy, "R7 preprogram zero", int'(all_zero), 1);
        end
        wait_done(tgt);
        for (int i = 0; i < SB; i++) read_check(i, "R6 sector0 erased");
        read_check(20, "R6 sector1 kept");
        read_check(63, "R6 sector3 kept");

        // R9: program that failed before now succeeds
        run_op(1'b0, 5, 8'h3C, "R9 reprogram");
        read_check(5, "R9 data");
        check(fail == 1'b0, "R9 fail low", int'(fail), 0);

        run_op(1'b1, 50, 8'h00, "R6 erase s3");
        read_check(63, "R6 sector3 erased");
        read_check(36, "R6 sector2 kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule